// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Sequencer

This block generates every refresh operation for an asynchronous page-mode DRAM and shares the RAS, CAS and WE strobes with a separate access controller. After reset it waits out a power-up pause. It then runs a short series of warm-up refreshes and reports that the memory is ready. From then on it spreads refreshes evenly over time. An interval timer adds one owed refresh per period. Refreshes are issued only while the access controller grants the bus, so they can be postponed up to a bounded debt. Once that debt reaches its cap, the block raises an urgent request.

A refresh is either column-before-row (CAS falls first, WE stays high, no address needed) or row-only (CAS stays high while RAS pulses and a wrapping row counter drives the address). An input selects between the two. A host can ask for low-power self refresh by holding a request level. The block first refreshes every row in one burst using column-before-row cycles, whatever the normal mode is. It then drops CAS and RAS and keeps them low for at least the minimum self-refresh time. When the request is released, it holds both strobes high for the exit precharge time. It then runs a second full burst before returning to distributed operation.

All times are given as clock-cycle counts through parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high, ras_n, cas_n and we_n are 1, and bus_req, bus_urgent, init_done and sr_active are 0.
- R2: During the first INIT_CYC clocks after reset, bus_req stays 0 and neither ras_n nor cas_n goes low.
- R3: After the pause, exactly WARMUP refresh cycles run, using the mode selected by ras_only. init_done then rises and stays high.
- R4: In normal operation one refresh becomes owed every INTERVAL clocks. With prompt grants, the number of refreshes over a window of N intervals is N plus or minus one.
- R5: A column-before-row refresh drops cas_n at least T_CSR clocks before ras_n falls, and keeps we_n at 1. ras_n stays low for exactly T_RAS clocks, and ras_n has been high for at least T_RP clocks before each fall.
- R6: When ras_only is 1, a refresh keeps cas_n at 1 for the whole RAS pulse and drives row_addr from a ROW_W-bit counter. The counter advances by one after each such refresh and wraps from all ones to zero.
- R7: Owed refreshes saturate at OWE_MAX. bus_req is 1 while any refresh is owed or in progress. bus_urgent is 1 exactly when the debt is at OWE_MAX, and it clears once the owed refreshes have run after a grant.
- R8: While sr_req is 1 in normal operation, the block runs BURST_ROWS column-before-row refreshes, even in row-only mode. It then drops cas_n, then ras_n, and raises sr_active with both strobes low.
- R9: Self refresh (sr_active, both strobes low) lasts at least SR_MIN clocks and ends only after sr_req returns to 0.
- R10: On self-refresh exit, ras_n and cas_n return to 1 and ras_n stays high for at least SR_PRE clocks. Then BURST_ROWS column-before-row refreshes run before distributed refreshing resumes.
- R11: ras_n or cas_n is low only while bus_gnt is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only | input | 1 | 1 selects row-only refresh for warm-up and normal operation |
| sr_req | input | 1 | Host level requesting self refresh |
| bus_gnt | input | 1 | Access controller grants the DRAM strobes to this block |
| bus_req | output | 1 | Request for the DRAM strobes |
| bus_urgent | output | 1 | Refresh debt is at its cap |
| init_done | output | 1 | Power-up pause and warm-up complete |
| sr_active | output | 1 | DRAM is held in self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Row address for row-only refresh |

## Verification
The checker covers several properties on every clock: strobe quietness during the power-up pause, CAS leading RAS on every column-first fall, row-counter stepping between row-only refreshes, the minimum self-refresh hold, strobes released high on exit, and no strobe activity without a grant. Other properties depend on counts across a whole scenario, and only the bench's scenarios show them. These are the warm-up count, the distributed refresh rate, debt saturation with withheld grants followed by the drain, the two full bursts around self refresh in row-only mode, and the precharge gap after exit.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    PH_INIT,
    PH_WARM,
    PH_RUN,
    PH_BURST_IN,
    PH_SR_CAS,
    PH_SR_HOLD,
    PH_SR_PRE,
    PH_BURST_OUT
  } phase_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CSR,
    SQ_RAS,
    SQ_RP
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL = 1560,
  parameter int OWE_MAX  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic take,
  output logic pending,
  output logic urgent
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam int OW = $clog2(OWE_MAX + 1);

  logic [TW-1:0] tmr;
  logic [OW-1:0] owed;
  logic          tick;
  logic          inc;
  logic          dec;

  assign tick = (tmr == TW'(INTERVAL - 1));
  assign inc  = tick && (owed != OW'(OWE_MAX));
  assign dec  = take && (owed != '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      tmr  <= '0;
      owed <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (inc && !dec)      owed <= owed + 1'b1;
      else if (dec && !inc) owed <= owed - 1'b1;
    end
  end

  assign pending = (owed != '0);
  assign urgent  = (owed == OW'(OWE_MAX));

endmodule

// File: rtl/rfsh_cycle_seq.sv
module rfsh_cycle_seq
  import dram_rfsh_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int T_CSR = 1,
  parameter int T_RAS = 5,
  parameter int T_RP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cbr,
  output logic             idle,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr
);
  localparam int CW = $clog2(imax(imax(T_CSR, T_RAS), T_RP) + 1);

  seq_state_t    st;
  logic [CW-1:0] cnt;
  logic          cbr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      cbr_q    <= 1'b0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      row_addr <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start) begin
            cbr_q <= cbr;
            if (cbr) begin
              cas_n <= 1'b0;
              cnt   <= CW'(T_CSR - 1);
              st    <= SQ_CSR;
            end else begin
              ras_n <= 1'b0;
              cnt   <= CW'(T_RAS - 1);
              st    <= SQ_RAS;
            end
          end
        end
        SQ_CSR: begin
          if (cnt == '0) begin
            ras_n <= 1'b0;
            cnt   <= CW'(T_RAS - 1);
            st    <= SQ_RAS;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_RAS: begin
          if (cnt == '0) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            cnt   <= CW'(T_RP - 1);
            st    <= SQ_RP;
            if (!cbr_q) row_addr <= row_addr + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) st <= SQ_IDLE;
          else           cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign idle = (st == SQ_IDLE);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int INIT_CYC   = 20000,
  parameter int WARMUP     = 8,
  parameter int INTERVAL   = 1560,
  parameter int OWE_MAX    = 8,
  parameter int BURST_ROWS = 4096,
  parameter int SR_MIN     = 10000,
  parameter int SR_PRE     = 11,
  parameter int ROW_W      = 12,
  parameter int T_CSR      = 1,
  parameter int T_RAS      = 5,
  parameter int T_RP       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_only,
  input  logic             sr_req,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             bus_urgent,
  output logic             init_done,
  output logic             sr_active,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);
  localparam int CNT_MAX = imax(imax(INIT_CYC, SR_MIN), imax(SR_PRE, T_CSR));
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int BW      = $clog2(imax(BURST_ROWS, WARMUP) + 1);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [BW-1:0] left;
  logic          sr_ras_n;
  logic          sr_cas_n;
  logic          we_q;

  logic seq_idle, seq_ras_n, seq_cas_n;
  logic pending, urgent;
  logic need, start, use_cbr, take, run;

  always_comb begin
    case (phase)
      PH_WARM, PH_BURST_IN, PH_BURST_OUT: need = (left != '0);
      PH_RUN:                             need = pending && !sr_req;
      default:                            need = 1'b0;
    endcase
  end

  assign start   = seq_idle && bus_gnt && need;
  assign use_cbr = (phase == PH_WARM || phase == PH_RUN) ? !ras_only : 1'b1;
  assign run     = (phase == PH_RUN);
  assign take    = start && run;

  rfsh_interval_timer #(
    .INTERVAL (INTERVAL),
    .OWE_MAX  (OWE_MAX)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .take    (take),
    .pending (pending),
    .urgent  (urgent)
  );

  rfsh_cycle_seq #(
    .ROW_W (ROW_W),
    .T_CSR (T_CSR),
    .T_RAS (T_RAS),
    .T_RP  (T_RP)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cbr      (use_cbr),
    .idle     (seq_idle),
    .ras_n    (seq_ras_n),
    .cas_n    (seq_cas_n),
    .row_addr (row_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_INIT;
      cnt      <= '0;
      left     <= '0;
      sr_ras_n <= 1'b1;
      sr_cas_n <= 1'b1;
      we_q     <= 1'b1;
    end else begin
      we_q <= 1'b1;
      case (phase)
        PH_INIT: begin
          if (cnt == CW'(INIT_CYC - 1)) begin
            phase <= PH_WARM;
            left  <= BW'(WARMUP);
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_WARM: begin
          if (start)                        left  <= left - 1'b1;
          else if (left == '0 && seq_idle)  phase <= PH_RUN;
        end
        PH_RUN: begin
          if (sr_req && seq_idle) begin
            phase <= PH_BURST_IN;
            left  <= BW'(BURST_ROWS);
          end
        end
        PH_BURST_IN: begin
          if (start) begin
            left <= left - 1'b1;
          end else if (left == '0 && seq_idle) begin
            phase    <= PH_SR_CAS;
            sr_cas_n <= 1'b0;
            cnt      <= '0;
          end
        end
        PH_SR_CAS: begin
          if (cnt == CW'(T_CSR - 1)) begin
            phase    <= PH_SR_HOLD;
            sr_ras_n <= 1'b0;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SR_HOLD: begin
          if (cnt >= CW'(SR_MIN - 1)) begin
            if (!sr_req) begin
              phase    <= PH_SR_PRE;
              sr_ras_n <= 1'b1;
              sr_cas_n <= 1'b1;
              cnt      <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SR_PRE: begin
          if (cnt == CW'(SR_PRE - 1)) begin
            phase <= PH_BURST_OUT;
            left  <= BW'(BURST_ROWS);
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (start)                        left  <= left - 1'b1;
          else if (left == '0 && seq_idle)  phase <= PH_RUN;
        end
      endcase
    end
  end

  assign bus_req    = (phase != PH_INIT) && ((phase != PH_RUN) || pending || !seq_idle);
  assign bus_urgent = urgent;
  assign init_done  = (phase != PH_INIT) && (phase != PH_WARM);
  assign sr_active  = (phase == PH_SR_HOLD);
  assign ras_n      = seq_ras_n & sr_ras_n;
  assign cas_n      = seq_cas_n & sr_cas_n;
  assign we_n       = we_q;

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int INIT_CYC = 20000,
  parameter int SR_MIN   = 10000,
  parameter int ROW_W    = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ras_n,
  input logic             cas_n,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             bus_urgent,
  input logic             sr_active,
  input logic [ROW_W-1:0] row_addr
);
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam int SW = $clog2(SR_MIN + 1);

  logic [IW-1:0]    init_cnt;
  logic [SW-1:0]    sr_cnt;
  logic [ROW_W-1:0] last_row;
  logic [ROW_W-1:0] next_row;
  logic             row_seen;
  logic             ro_fall;
  logic             ras_q;

  assign next_row = last_row + 1'b1;
  assign ro_fall  = ras_q && !ras_n && cas_n && !sr_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_cnt <= '0;
      sr_cnt   <= '0;
      last_row <= '0;
      row_seen <= 1'b0;
      ras_q    <= 1'b1;
    end else begin
      ras_q <= ras_n;
      if (init_cnt < IW'(INIT_CYC)) init_cnt <= init_cnt + 1'b1;
      if (!sr_active)                  sr_cnt <= '0;
      else if (sr_cnt < SW'(SR_MIN))   sr_cnt <= sr_cnt + 1'b1;
      if (ro_fall) begin
        last_row <= row_addr;
        row_seen <= 1'b1;
      end
    end
  end

  a_r2_quiet_init: assert property (@(posedge clk) disable iff (rst)
    (init_cnt < IW'(INIT_CYC)) |-> (ras_n && cas_n && !bus_req));

  a_r5_cas_leads: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

  a_r6_row_step: assert property (@(posedge clk) disable iff (rst)
    (ro_fall && row_seen) |-> (row_addr == next_row));

  a_r7_urgent_req: assert property (@(posedge clk) disable iff (rst)
    bus_urgent |-> bus_req);

  a_r9_sr_min_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_active) |-> (sr_cnt >= SW'(SR_MIN)));

  a_r10_exit_release: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_active) |-> (ras_n && cas_n));

  a_r11_grant_held: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || !cas_n) |-> bus_gnt);

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .INIT_CYC (INIT_CYC),
  .SR_MIN   (SR_MIN),
  .ROW_W    (ROW_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_urgent (bus_urgent),
  .sr_active  (sr_active),
  .row_addr   (row_addr)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_CYC   = 500;
  localparam int WARMUP     = 8;
  localparam int INTERVAL   = 40;
  localparam int OWE_MAX    = 4;
  localparam int BURST_ROWS = 64;
  localparam int SR_MIN     = 300;
  localparam int SR_PRE     = 4;
  localparam int ROW_W      = 6;
  localparam int ROWS       = 1 << ROW_W;
  localparam int T_CSR      = 1;
  localparam int T_RAS      = 3;
  localparam int T_RP       = 2;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_only = 1'b0;
  logic sr_req = 1'b0;
  logic bus_gnt = 1'b0;
  logic bus_req, bus_urgent, init_done, sr_active, ras_n, cas_n, we_n;
  logic [ROW_W-1:0] row_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_refresh_sched #(
    .INIT_CYC (INIT_CYC), .WARMUP (WARMUP), .INTERVAL (INTERVAL),
    .OWE_MAX (OWE_MAX), .BURST_ROWS (BURST_ROWS), .SR_MIN (SR_MIN),
    .SR_PRE (SR_PRE), .ROW_W (ROW_W), .T_CSR (T_CSR), .T_RAS (T_RAS),
    .T_RP (T_RP)
  ) u_dut (
    .clk (clk), .rst (rst), .ras_only (ras_only), .sr_req (sr_req),
    .bus_gnt (bus_gnt), .bus_req (bus_req), .bus_urgent (bus_urgent),
    .init_done (init_done), .sr_active (sr_active), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .row_addr (row_addr)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;
  int  cyc = 0;
  bit  blk = 1'b0;
  int  gnt_wait = 0;

  int  cbr_cnt = 0, ro_cnt = 0;
  int  first_req_cyc = -1, first_fall_cyc = -1;
  int  high_run = 1000, low_len = 0, cas_run = 0, sr_len = 0, sr_last_len = 0;
  int  last_row = 0, post_cbr = 0;
  bit  have_last = 0, saw_wrap = 0, pulse_normal = 0, pulse_ro = 0;
  bit  post_active = 0, post_done = 0, post_gap = 0;
  bit  prev_ras = 1, prev_sr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    if (rst) cyc = 0;
    else     cyc = cyc + 1;
  end

  // Access controller model: grant after a random latency, release with the request.
  always @(negedge clk) begin
    if (rst || !bus_req) begin
      bus_gnt  = 1'b0;
      gnt_wait = $urandom_range(0, 3);
    end else if (!bus_gnt && !blk) begin
      if (gnt_wait == 0) bus_gnt = 1'b1;
      else               gnt_wait--;
    end
  end

  // Strobe monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req && first_req_cyc < 0) first_req_cyc = cyc;
      if (prev_ras && !ras_n) begin
        if (first_fall_cyc < 0) first_fall_cyc = cyc;
        chk(bus_gnt, "R11 grant at RAS fall", int'(bus_gnt), 1);
        low_len = 0;
        if (!sr_active) begin
          pulse_normal = 1;
          chk(high_run >= T_RP, "R5 precharge before RAS", high_run, T_RP);
          if (post_gap) begin
            chk(high_run >= SR_PRE, "R10 exit precharge", high_run, SR_PRE);
            post_gap = 0;
          end
          if (!cas_n) begin
            cbr_cnt++;
            if (post_active) post_cbr++;
            chk(cas_run >= T_CSR, "R5 CAS lead", cas_run, T_CSR);
            chk(we_n, "R5 WE high", int'(we_n), 1);
          end else begin
            ro_cnt++;
            pulse_ro = 1;
            if (have_last) begin
              chk(int'(row_addr) == (last_row + 1) % ROWS, "R6 row step",
                  int'(row_addr), (last_row + 1) % ROWS);
              if (row_addr == '0) saw_wrap = 1;
            end
            have_last = 1;
            last_row  = int'(row_addr);
            if (post_active) begin
              post_active = 0;
              post_done   = 1;
            end
          end
        end else begin
          pulse_normal = 0;
        end
      end
      if (!ras_n) low_len++;
      if (!ras_n && pulse_ro && !cas_n) chk(0, "R6 CAS high in row-only", 0, 1);
      if (!prev_ras && ras_n) begin
        if (pulse_normal) chk(low_len == T_RAS, "R5 RAS width", low_len, T_RAS);
        pulse_normal = 0;
        pulse_ro     = 0;
      end
      if (sr_active) sr_len++;
      if (prev_sr && !sr_active) begin
        sr_last_len = sr_len;
        sr_len      = 0;
        post_active = 1;
        post_cbr    = 0;
        post_gap    = 1;
      end
      high_run = ras_n ? high_run + 1 : 0;
      cas_run  = cas_n ? 0 : cas_run + 1;
      prev_ras = ras_n;
      prev_sr  = sr_active;
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD_LIMIT, 0);
    report();
  end

  initial begin
    int seed_v;
    int cnt;
    int hold;
    seed_v = $urandom(32'd4711);

    repeat (5) step();
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", int'({ras_n, cas_n, we_n}), 7);
    chk(!bus_req && !bus_urgent, "R1 no request in reset", int'({bus_req, bus_urgent}), 0);
    chk(!init_done && !sr_active, "R1 status low in reset", int'({init_done, sr_active}), 0);
    rst = 1'b0;

    // R2 / R3: pause then warm-up
    while (!init_done) step();
    chk(first_req_cyc >= INIT_CYC, "R2 request after pause", first_req_cyc, INIT_CYC);
    chk(first_fall_cyc >= INIT_CYC, "R2 RAS after pause", first_fall_cyc, INIT_CYC);
    chk(cbr_cnt == WARMUP, "R3 warm-up count", cbr_cnt, WARMUP);
    chk(ro_cnt == 0, "R3 warm-up mode", ro_cnt, 0);

    // R4: distributed rate, column-first mode
    cbr_cnt = 0;
    repeat (20 * INTERVAL) step();
    chk(cbr_cnt >= 19 && cbr_cnt <= 21, "R4 refresh rate", cbr_cnt, 20);
    chk(init_done, "R3 init_done stays high", int'(init_done), 1);

    // R6: row-only mode with counter wrap
    ras_only  = 1'b1;
    have_last = 0;
    saw_wrap  = 0;
    ro_cnt    = 0;
    while (ro_cnt < ROWS + 6) step();
    chk(saw_wrap, "R6 row counter wrap", int'(saw_wrap), 1);

    // R7: withheld grants, saturation, drain
    blk = 1'b1;
    while (bus_gnt) step();
    step();
    cbr_cnt = 0;
    ro_cnt  = 0;
    repeat ((OWE_MAX + 2) * INTERVAL) step();
    chk(bus_urgent, "R7 urgent at cap", int'(bus_urgent), 1);
    chk(bus_req, "R7 request held", int'(bus_req), 1);
    chk(cbr_cnt + ro_cnt == 0, "R7 no refresh without grant", cbr_cnt + ro_cnt, 0);
    blk = 1'b0;
    while (bus_req) step();
    cnt = cbr_cnt + ro_cnt;
    chk(cnt >= OWE_MAX && cnt <= OWE_MAX + 1, "R7 drained debt", cnt, OWE_MAX);
    chk(!bus_urgent, "R7 urgent cleared", int'(bus_urgent), 0);

    // R8 / R9 / R10: self refresh while in row-only mode
    cbr_cnt   = 0;
    ro_cnt    = 0;
    post_done = 0;
    sr_req    = 1'b1;
    while (!sr_active) step();
    chk(cbr_cnt == BURST_ROWS, "R8 entry burst count", cbr_cnt, BURST_ROWS);
    chk(ro_cnt == 0, "R8 entry burst is column-first", ro_cnt, 0);
    chk(!ras_n && !cas_n, "R8 strobes low in self refresh", int'({ras_n, cas_n}), 0);
    hold = $urandom_range(50, 150);
    repeat (hold) step();
    sr_req = 1'b0;
    step();
    chk(sr_active, "R9 short request still held", int'(sr_active), 1);
    while (!post_done) step();
    chk(sr_last_len >= SR_MIN, "R9 minimum self-refresh time", sr_last_len, SR_MIN);
    chk(post_cbr == BURST_ROWS, "R10 exit burst count", post_cbr, BURST_ROWS);

    // R9: long self refresh in column-first mode
    ras_only = 1'b0;
    step();
    sr_req = 1'b1;
    while (!sr_active) step();
    hold = $urandom_range(SR_MIN + 20, SR_MIN + 120);
    repeat (hold) step();
    chk(sr_active, "R9 held while requested", int'(sr_active), 1);
    sr_req = 1'b0;
    while (sr_active) step();
    step();
    chk(sr_last_len >= hold, "R9 ends after release", sr_last_len, hold);
    repeat (BURST_ROWS * (T_CSR + T_RAS + T_RP + 6)) step();
    chk(post_cbr >= BURST_ROWS, "R10 exit burst in column-first mode", post_cbr, BURST_ROWS);

    // Random grant blocking in mixed modes
    for (int i = 0; i < 6; i++) begin
      int blen;
      ras_only = 1'($urandom_range(0, 1));
      blen = $urandom_range(0, 7);
      blk = 1'b1;
      repeat (blen * INTERVAL) step();
      if (blen >= OWE_MAX + 2) chk(bus_urgent, "R7 urgent after long block", int'(bus_urgent), 1);
      blk = 1'b0;
      repeat (3 * INTERVAL) step();
      chk(!bus_urgent, "R7 urgent clears after drain", int'(bus_urgent), 0);
    end

    report();
  end

endmodule